// File: doc/BRIEF.md
# Audio Master Clock Prescaler

This block derives the three clocks of a stereo audio serial port from one kernel clock: a master clock for an external converter, a bit clock, and a word-select (frame) clock. A programmable prescaler divides the kernel clock by N = 2×DIV + ODD. When N is odd, the high phase is one cycle longer than the low phase. With the master clock output enabled, the prescaled clock appears on `mclk_o` and a further fixed divide-by-M (M = 8 for 16-bit channels, 4 for 32-bit channels) produces the bit clock. With the master clock disabled, the prescaled clock drives the bit clock directly and `mclk_o` stays low. In both frame widths the master clock therefore runs at 256 times the frame rate.

The kernel clock is the only clock. The bit clock and the word select are registered levels, and two single-cycle strobes mark the kernel cycles in which the bit clock has just risen or fallen, so a serializer in the same domain can shift on them. A configuration word can be written at any time. It is held pending and, together with the frame-width input, becomes active only at the start of the next frame (word select falling), so the output never carries a shortened pulse.

Four state machines make up the block. The configuration holder has the states CFG_IDLE and CFG_ARMED: a write moves it to CFG_ARMED, and a frame start moves it back to CFG_IDLE. The prescaler has the states PH_LOW and PH_HIGH, and it swaps between them when its phase counter reaches zero. The bit-clock stage has the states BC_LOW and BC_HIGH, and it swaps on a prescaler edge, or on every M/2-th prescaler falling edge when the master clock is on. The frame stage has the states WS_LEFT and WS_RIGHT, and it swaps on the bit-clock fall that completes a channel. The move from WS_RIGHT to WS_LEFT is the frame start.

Top module: `aclk_prescaler`

## Requirements
- R1: During and after reset all outputs are low, and until the first frame start the block runs with DIV=2, ODD=0, master clock off and 16-bit channels (bit clock period 4 kernel cycles).
- R2: A configuration write takes DIV from `cfg_wdata[7:0]`, ODD from bit 8 and the master clock enable from bit 9, and the prescale ratio is N = 2×DIV + ODD kernel cycles.
- R3: A written DIV below 2 (0 or 1) behaves exactly as DIV = 2.
- R4: The prescaled clock is low for DIV cycles and high for DIV + ODD cycles, starting low at each frame start.
- R5: With the master clock enable at 0, the bit clock is the prescaled clock (low DIV, high DIV+ODD cycles) and `mclk_o` stays low for the whole frame.
- R6: With the master clock enable at 1, the bit clock has a 50 % duty cycle and a period of M×N cycles, where M = 8 when `wide_frame` was 0 and M = 4 when it was 1 at the frame start.
- R7: Word select starts low at a frame start and toggles only on a bit-clock falling edge, after 16 bit-clock periods (`wide_frame` = 0) or 32 (`wide_frame` = 1), so one frame is two channels long.
- R8: A configuration write and the `wide_frame` input have no effect until the next word-select falling edge. The frame in which a write occurs keeps the old timing.
- R9: `bclk_rise_stb` is high for exactly the kernel cycles in which `bclk_o` has just gone from 0 to 1, and `bclk_fall_stb` for exactly those in which it has just gone from 1 to 0.
- R10: With the master clock enabled, `mclk_o` rises 256 times per frame for both frame widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kclk | input | 1 | Kernel clock; the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration word: [7:0] DIV, [8] ODD, [9] master clock enable |
| wide_frame | input | 1 | 1 selects 32-bit channels, 0 selects 16-bit; sampled at frame start |
| mclk_o | output | 1 | Master clock, low when disabled |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, low for the first channel of a frame |
| bclk_rise_stb | output | 1 | One-cycle mark of a bit-clock rising edge |
| bclk_fall_stb | output | 1 | One-cycle mark of a bit-clock falling edge |

## Verification
The assertions check on every cycle that each strobe coincides with a real bit-clock edge and that the bit clock never moves without one. They also check that word select changes only on a bit-clock fall, and that the active configuration changes only when word select falls. The exact phase lengths for odd and even ratios, the clamp of small dividers, the master-clock count per frame and the deferral of a write to the following frame are numeric timing properties. Only the bench's per-frame measurements against configurations written mid-frame can show those.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int DIV_W = 8;
    localparam int CFG_W = DIV_W + 2;
    localparam int ACT_W = CFG_W + 1;

    typedef struct packed {
        logic             mck_en;
        logic             odd;
        logic [DIV_W-1:0] div;
    } pre_cfg_t;

    typedef enum logic {CFG_IDLE, CFG_ARMED} cfg_state_e;
    typedef enum logic {PH_LOW, PH_HIGH}     phase_e;
    typedef enum logic {BC_LOW, BC_HIGH}     bclk_state_e;
    typedef enum logic {WS_LEFT, WS_RIGHT}   ws_state_e;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
        return (d < DIV_W'(2)) ? DIV_W'(2) : d;
    endfunction

endpackage

// File: rtl/aclk_cfg_hold.sv
module aclk_cfg_hold
    import aclk_pkg::*;
#(
    parameter int RST_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             wide_in,
    input  logic             apply,
    output pre_cfg_t         act_cfg,
    output logic             act_wide,
    output pre_cfg_t         nxt_cfg
);

    localparam logic [DIV_W-1:0] RST_D = clamp_div(DIV_W'(RST_DIV));
    localparam pre_cfg_t RST_CFG = '{mck_en: 1'b0, odd: 1'b0, div: RST_D};

    cfg_state_e st, st_n;
    pre_cfg_t   pend_q, act_q, wr_cfg;
    logic       wide_q;

    always_comb begin
        wr_cfg.div    = clamp_div(wdata[DIV_W-1:0]);
        wr_cfg.odd    = wdata[DIV_W];
        wr_cfg.mck_en = wdata[DIV_W+1];
    end

    always_comb begin
        st_n = st;
        unique case (st)
            CFG_IDLE:  if (we) st_n = CFG_ARMED;
            CFG_ARMED: if (apply && !we) st_n = CFG_IDLE;
            default:   st_n = CFG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= CFG_IDLE;
            pend_q <= RST_CFG;
            act_q  <= RST_CFG;
            wide_q <= 1'b0;
        end else begin
            st <= st_n;
            if (we) pend_q <= wr_cfg;
            if (apply) begin
                wide_q <= wide_in;
                if (st == CFG_ARMED) act_q <= pend_q;
            end
        end
    end

    always_comb begin
        act_cfg  = act_q;
        act_wide = wide_q;
        nxt_cfg  = (apply && st == CFG_ARMED) ? pend_q : act_q;
    end

endmodule

// File: rtl/aclk_phase_gen.sv
module aclk_phase_gen
    import aclk_pkg::*;
#(
    parameter int RST_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] ld_div,
    input  logic             ld_odd,
    output logic             lvl,
    output logic             rise_ev,
    output logic             fall_ev
);

    localparam logic [DIV_W-1:0] RST_D = clamp_div(DIV_W'(RST_DIV));

    phase_e           st, st_n;
    logic [DIV_W-1:0] cnt_q, cnt_n;
    logic [DIV_W-1:0] lo_ld, hi_ld;

    // low phase lasts DIV cycles, high phase DIV+ODD cycles
    assign lo_ld = ld_div - DIV_W'(1);
    assign hi_ld = ld_div - DIV_W'(1) + {{(DIV_W-1){1'b0}}, ld_odd};

    always_comb begin
        st_n  = st;
        cnt_n = cnt_q - DIV_W'(1);
        unique case (st)
            PH_LOW: begin
                if (cnt_q == '0) begin
                    st_n  = PH_HIGH;
                    cnt_n = hi_ld;
                end
            end
            PH_HIGH: begin
                if (cnt_q == '0) begin
                    st_n  = PH_LOW;
                    cnt_n = lo_ld;
                end
            end
            default: begin
                st_n  = PH_LOW;
                cnt_n = lo_ld;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= PH_LOW;
            cnt_q <= RST_D - DIV_W'(1);
        end else begin
            st    <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        lvl     = (st == PH_HIGH);
        rise_ev = (st == PH_LOW)  && (cnt_q == '0);
        fall_ev = (st == PH_HIGH) && (cnt_q == '0);
    end

endmodule

// File: rtl/aclk_bit_gen.sv
module aclk_bit_gen
    import aclk_pkg::*;
#(
    parameter int NARROW_MDIV = 8,
    parameter int WIDE_MDIV   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic p_rise,
    input  logic p_fall,
    input  logic mck_en,
    input  logic wide,
    input  logic restart,
    output logic lvl,
    output logic b_rise,
    output logic b_fall
);

    localparam int M_MAX    = (NARROW_MDIV > WIDE_MDIV) ? NARROW_MDIV : WIDE_MDIV;
    localparam int HALF_MAX = M_MAX / 2;
    localparam int MCNT_W   = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;
    localparam logic [MCNT_W-1:0] N_LAST = MCNT_W'(NARROW_MDIV / 2 - 1);
    localparam logic [MCNT_W-1:0] W_LAST = MCNT_W'(WIDE_MDIV / 2 - 1);

    bclk_state_e       st, st_n;
    logic [MCNT_W-1:0] mcnt_q, mcnt_n;
    logic [MCNT_W-1:0] half_last;
    logic              edge_hit, step;

    assign half_last = wide ? W_LAST : N_LAST;
    assign edge_hit  = p_fall && (mcnt_q == half_last);

    // step: the current cycle closes a bit-clock half period
    always_comb begin
        if (mck_en) step = edge_hit;
        else        step = (st == BC_LOW) ? p_rise : p_fall;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            BC_LOW:  if (step) st_n = BC_HIGH;
            BC_HIGH: if (step) st_n = BC_LOW;
            default: st_n = BC_LOW;
        endcase
    end

    always_comb begin
        if (restart || !mck_en) mcnt_n = '0;
        else if (p_fall)        mcnt_n = edge_hit ? '0 : mcnt_q + MCNT_W'(1);
        else                    mcnt_n = mcnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= BC_LOW;
            mcnt_q <= '0;
        end else begin
            st     <= st_n;
            mcnt_q <= mcnt_n;
        end
    end

    always_comb begin
        lvl    = (st == BC_HIGH);
        b_rise = step && (st == BC_LOW);
        b_fall = step && (st == BC_HIGH);
    end

endmodule

// File: rtl/aclk_frame_gen.sv
module aclk_frame_gen
    import aclk_pkg::*;
#(
    parameter int NARROW_BITS = 16,
    parameter int WIDE_BITS   = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic b_fall,
    input  logic wide,
    output logic ws,
    output logic boundary
);

    localparam int BITS_MAX = (NARROW_BITS > WIDE_BITS) ? NARROW_BITS : WIDE_BITS;
    localparam int BCNT_W   = $clog2(BITS_MAX);
    localparam logic [BCNT_W-1:0] N_LAST = BCNT_W'(NARROW_BITS - 1);
    localparam logic [BCNT_W-1:0] W_LAST = BCNT_W'(WIDE_BITS - 1);

    ws_state_e         st, st_n;
    logic [BCNT_W-1:0] bcnt_q, bcnt_n;
    logic              wrap;

    assign wrap = b_fall && (bcnt_q == (wide ? W_LAST : N_LAST));

    always_comb begin
        st_n = st;
        unique case (st)
            WS_LEFT:  if (wrap) st_n = WS_RIGHT;
            WS_RIGHT: if (wrap) st_n = WS_LEFT;
            default:  st_n = WS_LEFT;
        endcase
    end

    always_comb begin
        if (wrap)        bcnt_n = '0;
        else if (b_fall) bcnt_n = bcnt_q + BCNT_W'(1);
        else             bcnt_n = bcnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= WS_LEFT;
            bcnt_q <= '0;
        end else begin
            st     <= st_n;
            bcnt_q <= bcnt_n;
        end
    end

    always_comb begin
        ws       = (st == WS_RIGHT);
        boundary = wrap && (st == WS_RIGHT);
    end

endmodule

// File: rtl/aclk_prescaler.sv
module aclk_prescaler
    import aclk_pkg::*;
#(
    parameter int RST_DIV     = 2,
    parameter int NARROW_BITS = 16,
    parameter int WIDE_BITS   = 32,
    parameter int NARROW_MDIV = 8,
    parameter int WIDE_MDIV   = 4
) (
    input  logic             kclk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             wide_frame,
    output logic             mclk_o,
    output logic             bclk_o,
    output logic             ws_o,
    output logic             bclk_rise_stb,
    output logic             bclk_fall_stb
);

    pre_cfg_t         act_cfg, nxt_cfg;
    logic             act_wide;
    logic             frame_start;
    logic             p_lvl, p_rise, p_fall;
    logic             b_lvl, b_rise, b_fall;
    logic             ws_lvl;
    logic             rise_q, fall_q;
    logic [ACT_W-1:0] cfg_act_bits;

    aclk_cfg_hold #(.RST_DIV(RST_DIV)) u_cfg (
        .clk      (kclk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .wide_in  (wide_frame),
        .apply    (frame_start),
        .act_cfg  (act_cfg),
        .act_wide (act_wide),
        .nxt_cfg  (nxt_cfg)
    );

    aclk_phase_gen #(.RST_DIV(RST_DIV)) u_phase (
        .clk     (kclk),
        .rst_n   (rst_n),
        .ld_div  (nxt_cfg.div),
        .ld_odd  (nxt_cfg.odd),
        .lvl     (p_lvl),
        .rise_ev (p_rise),
        .fall_ev (p_fall)
    );

    aclk_bit_gen #(.NARROW_MDIV(NARROW_MDIV), .WIDE_MDIV(WIDE_MDIV)) u_bit (
        .clk     (kclk),
        .rst_n   (rst_n),
        .p_rise  (p_rise),
        .p_fall  (p_fall),
        .mck_en  (act_cfg.mck_en),
        .wide    (act_wide),
        .restart (frame_start),
        .lvl     (b_lvl),
        .b_rise  (b_rise),
        .b_fall  (b_fall)
    );

    aclk_frame_gen #(.NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)) u_frame (
        .clk      (kclk),
        .rst_n    (rst_n),
        .b_fall   (b_fall),
        .wide     (act_wide),
        .ws       (ws_lvl),
        .boundary (frame_start)
    );

    // edge marks register on the same edge that moves the bit clock
    always_ff @(posedge kclk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= b_rise;
            fall_q <= b_fall;
        end
    end

    assign cfg_act_bits  = {act_wide, act_cfg};
    assign mclk_o        = p_lvl & act_cfg.mck_en;
    assign bclk_o        = b_lvl;
    assign ws_o          = ws_lvl;
    assign bclk_rise_stb = rise_q;
    assign bclk_fall_stb = fall_q;

endmodule

// File: rtl/aclk_prescaler_chk.sv
module aclk_prescaler_chk
    import aclk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bclk,
    input logic             ws,
    input logic             rise_stb,
    input logic             fall_stb,
    input logic [ACT_W-1:0] act_bits
);

    // R9
    rise_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (bclk && !$past(bclk)));

    // R9
    fall_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (!bclk && $past(bclk)));

    // R9
    bclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_stb && !fall_stb) |-> $stable(bclk));

    // R7
    ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ws != $past(ws)) |-> fall_stb);

    // R8
    cfg_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_bits != $past(act_bits)) |-> $fell(ws));

endmodule

bind aclk_prescaler aclk_prescaler_chk u_chk (
    .clk      (kclk),
    .rst_n    (rst_n),
    .bclk     (bclk_o),
    .ws       (ws_o),
    .rise_stb (bclk_rise_stb),
    .fall_stb (bclk_fall_stb),
    .act_bits (cfg_act_bits)
);

// File: tb/aclk_prescaler_test.sv
module aclk_prescaler_test;

    logic       kclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [9:0] cfg_wdata = '0;
    logic       wide_frame = 1'b0;
    logic       mclk_o, bclk_o, ws_o, bclk_rise_stb, bclk_fall_stb;

    always #5 kclk = ~kclk;

    aclk_prescaler uut (
        .kclk          (kclk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .wide_frame    (wide_frame),
        .mclk_o        (mclk_o),
        .bclk_o        (bclk_o),
        .ws_o          (ws_o),
        .bclk_rise_stb (bclk_rise_stb),
        .bclk_fall_stb (bclk_fall_stb)
    );

    typedef struct {
        int    blo, bhi, wslo, flen, mrises, mlo, mhi, nstb, en;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   nchk = 0, nerr = 0;
    bit   done = 0;

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected timing of one frame, from the requirements
    function automatic exp_t model(int div, int odd, int en, int wide, string tag);
        exp_t e;
        int d, n, bits, m, bper;
        d    = (div < 2) ? 2 : div;
        n    = 2 * d + odd;
        bits = wide ? 32 : 16;
        m    = wide ? 4 : 8;
        if (en != 0) begin
            e.blo = (m / 2) * n; e.bhi = (m / 2) * n; bper = m * n;
            e.mlo = d; e.mhi = d + odd;
        end else begin
            e.blo = d; e.bhi = d + odd; bper = n;
            e.mlo = 0; e.mhi = 0;
        end
        e.wslo   = bits * bper;
        e.flen   = 2 * e.wslo;
        e.mrises = (en != 0) ? e.flen / n : 0;
        e.nstb   = 2 * bits;
        e.en     = en;
        e.tag    = tag;
        return e;
    endfunction

    // monitor: measures each frame and compares with the queued expectation
    int t = 0, r1 = 0, f1 = 0, wr = 0, mr = 0, mr1 = 0, mf1 = 0, nr = 0, nf = 0, mism = 0;
    bit started = 0;
    logic pb = 0, pw = 0, pm = 0;

    always @(negedge kclk) begin
        if (!rst_n) begin
            started = 0; pb = 0; pw = 0; pm = 0;
        end else begin
            if (started) begin
                t++;
                if (bclk_rise_stb != (bclk_o && !pb) || bclk_fall_stb != (!bclk_o && pb)) mism++;
                if (bclk_rise_stb) nr++;
                if (bclk_fall_stb) nf++;
                if (bclk_o && !pb && r1 == 0) r1 = t;
                if (!bclk_o && pb && r1 != 0 && f1 == 0) f1 = t;
                if (ws_o && !pw && wr == 0) wr = t;
                if (mclk_o && !pm) begin mr++; if (mr == 1) mr1 = t; end
                if (!mclk_o && pm && mr1 != 0 && mf1 == 0) mf1 = t;
            end
            if (!ws_o && pw) begin
                if (started && sbq.size() > 0) begin
                    exp_t e;
                    string bq, mq;
                    e  = sbq.pop_front();
                    bq = (e.en != 0) ? "R6" : "R5";
                    mq = (e.en != 0) ? "R10" : "R5";
                    chk({bq, " ", e.tag}, "bclk low length", r1, e.blo);
                    chk({bq, " ", e.tag}, "bclk high length", f1 - r1, e.bhi);
                    chk({"R7 ", e.tag}, "ws low length", wr, e.wslo);
                    chk({"R7 ", e.tag}, "frame length", t, e.flen);
                    chk({mq, " ", e.tag}, "mclk rises per frame", mr, e.mrises);
                    chk({mq, " ", e.tag}, "mclk first low length", mr1, e.mlo);
                    chk({mq, " ", e.tag}, "mclk high length", (mf1 != 0) ? mf1 - mr1 : 0, e.mhi);
                    chk({"R9 ", e.tag}, "rise marks", nr, e.nstb);
                    chk({"R9 ", e.tag}, "fall marks", nf, e.nstb);
                    chk({"R9 ", e.tag}, "mark mismatches", mism, 0);
                end
                started = 1;
                t = 0; r1 = 0; f1 = 0; wr = 0; mr = 0; mr1 = 0; mf1 = 0; nr = 0; nf = 0; mism = 0;
            end
            pb = bclk_o; pw = ws_o; pm = mclk_o;
        end
    end

    task automatic wait_frame();
        logic prev;
        do begin
            prev = ws_o;
            @(negedge kclk);
        end while (!(prev && !ws_o));
    endtask

    int    c_div = 2, c_odd = 0, c_en = 0, c_wide = 0;
    string c_tag = "R1 R8";

    // driver: queue the current frame's timing, write the next setting mid-frame
    task automatic step(int div, int odd, int en, int wide, string tag);
        @(negedge kclk);
        sbq.push_back(model(c_div, c_odd, c_en, c_wide, {c_tag, " R8"}));
        repeat (10) @(negedge kclk);
        cfg_wdata  = {en[0], odd[0], div[7:0]};
        wide_frame = wide[0];
        cfg_we     = 1'b1;
        @(negedge kclk);
        cfg_we     = 1'b0;
        wait_frame();
        c_div = div; c_odd = odd; c_en = en; c_wide = wide; c_tag = tag;
    endtask

    initial begin
        repeat (3) @(negedge kclk);
        chk("R1", "bclk in reset", bclk_o, 0);
        chk("R1", "ws in reset", ws_o, 0);
        chk("R1", "mclk in reset", mclk_o, 0);
        chk("R1", "marks in reset", bclk_rise_stb | bclk_fall_stb, 0);
        rst_n = 1'b1;
        @(negedge kclk);
        chk("R1", "bclk after reset", bclk_o, 0);
        chk("R1", "ws after reset", ws_o, 0);
        wait_frame();
        step(3, 1, 0, 0, "R2 R4");
        step(2, 1, 1, 0, "R2 R4");
        step(4, 0, 1, 1, "R2");
        step(1, 0, 0, 1, "R3");
        step(0, 1, 1, 0, "R3 R4");
        step(5, 0, 0, 1, "R2");
        @(negedge kclk);
        sbq.push_back(model(c_div, c_odd, c_en, c_wide, c_tag));
        wait_frame();
        repeat (4) @(negedge kclk);
        chk("R8", "unchecked frames left", sbq.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge kclk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R7 watchdog: actual=%0d expected=%0d cycles", 200000, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule